// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block models the controller that runs inside a byte-wide NOR flash while it programs or erases, without the real storage cells. A small register bank stands in for the array, so the final contents can be read back. Single-cycle pulses start an operation:

- a byte program, with its address and data;
- a block erase, with a block index;
- a chip erase;
- a suspend, a resume or a reset.

All durations are counted in clock cycles and set by parameters.

A read is a one-cycle strobe with an address. The result appears on `rdData` one clock later. While the controller is working, a read returns a status byte instead of array data:

- bit 7 is the data-polling bit;
- bit 6 flips on every read;
- bit 5 flags an operation that ran past its time limit;
- bit 3 shows whether an erase has really begun;
- bits 4, 2, 1 and 0 are always zero.

A block erase first opens a collection window. Every further block-erase request inside that window adds its block to the set and starts the window again. Erase can be suspended so that blocks outside the erase set can be read. Each block can be protected by a mask input.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset, every stored byte reads FFh and `busy` and `suspended` are 0. An idle read returns the stored byte at `rdAddr` on `rdData` one clock after the strobe.
- R2: A program to an unprotected block raises `busy`. While it runs, status bit 7 is the inverse of bit 7 of the new data. On completion the byte holds the old value ANDed with the new data.
- R3: Status bit 6 inverts on each read while busy. It does not change across reads while suspended.
- R4: A program that would need any bit to go from 0 to 1 never completes. After FAIL_LIMIT cycles status bit 5 reads 1 and `busy` stays 1 until a reset command. The reset returns the block to idle with the byte unchanged.
- R5: After a block-erase request, status bit 3 reads 0 during the collection window and 1 once erasing starts. Bit 7 reads 0 throughout. On completion every byte of the selected blocks reads FFh.
- R6: A block-erase request received inside the window adds its block to the set and restarts the full window.
- R7: If every selected block is protected, status is returned (bit 7 = 0, bit 3 = 1, bit 6 toggling) for PROT_CYCLES. The block then returns to idle with the data unchanged.
- R8: A program to a byte whose block bit in `protMask` is 1 is dropped: `busy` never rises and the byte is unchanged.
- R9: A suspend during the window or during erasing sets `suspended` and clears `busy`. Reads outside the erase set return stored data; reads inside it return status. A resume continues the erase to completion.
- R10: While a program is running, reset, suspend and erase requests are ignored and the program completes normally.
- R11: A reset during the window, erase or suspension aborts the erase and leaves the data unchanged. `busy` stays 1 for RECOVER_CYCLES, during which new commands are ignored.
- R12: Status reads always give 0 on bits 4, 2, 1 and 0.
- R13: A chip erase starts erasing at once (bit 3 = 1, no window). It sets every byte of every unprotected block to FFh and leaves protected blocks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progStart | input | 1 | Start a byte program (one-cycle pulse) |
| progAddr | input | ADDR_W | Byte address to program |
| progData | input | 8 | Data to program |
| blkEraseStart | input | 1 | Block-erase request (one-cycle pulse) |
| blkIdx | input | BLK_W | Block to erase |
| chipEraseStart | input | 1 | Chip-erase request |
| suspendReq | input | 1 | Suspend an erase |
| resumeReq | input | 1 | Resume a suspended erase |
| resetCmd | input | 1 | Reset command |
| protMask | input | NUM_BLOCKS | Per-block protection, 1 = protected |
| rdStrobe | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read result, one clock after the strobe |
| busy | output | 1 | Operation running, failed or recovering |
| suspended | output | 1 | Erase suspended |

## Verification
Window restart is checked by reading bit 3 after the first window would already have expired. A design that does not restart the window reports erasing too early there.

A 0-to-1 program must hang and keep bit 5 set until a reset. A design that simply writes the byte would drop `busy` and corrupt the stored value instead.

Requests issued while a program runs, and during the recovery time after an aborted erase, must not change the stored data or start a new operation. A design that accepts them would erase a block or program a byte.

Bit 6 is compared across two reads, both while busy and while suspended. A design that toggles during suspension, or stalls the toggle while busy, fails those comparisons.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WINDOW,
    ST_ERASE,
    ST_SUSP,
    ST_PROTWAIT,
    ST_FAIL,
    ST_RECOVER
  } peState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchProg;
    logic commitProg;
    logic commitErase;
  } peStrobe_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int NUM_BLOCKS     = 8,
  parameter int BLK_W          = 3,
  parameter int PROG_CYCLES    = 10,
  parameter int FAIL_LIMIT     = 40,
  parameter int ERASE_CYCLES   = 30,
  parameter int WINDOW_CYCLES  = 12,
  parameter int PROT_CYCLES    = 15,
  parameter int RECOVER_CYCLES = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  progStart,
  input  logic [BLK_W-1:0]      progBlk,
  input  logic                  blkEraseStart,
  input  logic [BLK_W-1:0]      blkIdx,
  input  logic                  chipEraseStart,
  input  logic                  suspendReq,
  input  logic                  resumeReq,
  input  logic                  resetCmd,
  input  logic [NUM_BLOCKS-1:0] protMask,
  input  logic                  rdStrobe,
  input  logic [BLK_W-1:0]      rdBlk,
  input  logic                  progBad,
  input  logic                  progBit7,
  output peStrobe_t             strobe,
  output logic [NUM_BLOCKS-1:0] eraseMask,
  output logic                  rdStatus,
  output logic [7:0]            statusByte,
  output logic                  busy,
  output logic                  suspended
);

  localparam int MAX_A  = maxOf(PROG_CYCLES, FAIL_LIMIT);
  localparam int MAX_B  = maxOf(ERASE_CYCLES, WINDOW_CYCLES);
  localparam int MAX_C  = maxOf(PROT_CYCLES, RECOVER_CYCLES);
  localparam int MAX_ALL = maxOf(maxOf(MAX_A, MAX_B), MAX_C);
  localparam int CNT_W  = $clog2(MAX_ALL + 1);
  localparam logic [CNT_W-1:0] PROG_END  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] FAIL_END  = CNT_W'(FAIL_LIMIT - 1);
  localparam logic [CNT_W-1:0] ERASE_END = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WIN_END   = CNT_W'(WINDOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] PROT_END  = CNT_W'(PROT_CYCLES - 1);
  localparam logic [CNT_W-1:0] REC_END   = CNT_W'(RECOVER_CYCLES - 1);

  peState_t              st, stNext;
  logic [CNT_W-1:0]      cnt, cntNext;
  logic [NUM_BLOCKS-1:0] eraseSet, setNext;
  logic                  tog;
  logic                  toggling;

  always_comb begin
    stNext  = st;
    cntNext = cnt + 1'b1;
    setNext = eraseSet;
    strobe  = '0;
    unique case (st)
      ST_IDLE: begin
        cntNext = '0;
        if (progStart) begin
          if (!protMask[progBlk]) begin
            strobe.latchProg = 1'b1;
            stNext = ST_PROG;
          end
        end else if (blkEraseStart) begin
          setNext = NUM_BLOCKS'(1) << blkIdx;
          stNext  = ST_WINDOW;
        end else if (chipEraseStart) begin
          if ((~protMask) != '0) begin
            setNext = ~protMask;
            stNext  = ST_ERASE;
          end else begin
            setNext = '0;
            stNext  = ST_PROTWAIT;
          end
        end
      end
      ST_PROG: begin
        if (progBad) begin
          if (cnt == FAIL_END) stNext = ST_FAIL;
        end else if (cnt == PROG_END) begin
          strobe.commitProg = 1'b1;
          stNext = ST_IDLE;
        end
      end
      ST_WINDOW: begin
        if (resetCmd) begin
          stNext = ST_RECOVER; cntNext = '0; setNext = '0;
        end else if (suspendReq) begin
          stNext = ST_SUSP; cntNext = '0; setNext = eraseSet & ~protMask;
        end else if (blkEraseStart) begin
          setNext = eraseSet | (NUM_BLOCKS'(1) << blkIdx);
          cntNext = '0;
        end else if (cnt == WIN_END) begin
          cntNext = '0;
          setNext = eraseSet & ~protMask;
          stNext  = ((eraseSet & ~protMask) != '0) ? ST_ERASE : ST_PROTWAIT;
        end
      end
      ST_ERASE: begin
        if (resetCmd) begin
          stNext = ST_RECOVER; cntNext = '0; setNext = '0;
        end else if (suspendReq) begin
          stNext = ST_SUSP; cntNext = cnt;
        end else if (cnt == ERASE_END) begin
          strobe.commitErase = 1'b1;
          setNext = '0;
          stNext  = ST_IDLE;
        end
      end
      ST_SUSP: begin
        cntNext = cnt;
        if (resetCmd) begin
          stNext = ST_RECOVER; cntNext = '0; setNext = '0;
        end else if (resumeReq) begin
          stNext = ST_ERASE;
        end
      end
      ST_PROTWAIT: begin
        if (cnt == PROT_END) begin
          stNext = ST_IDLE; setNext = '0;
        end
      end
      ST_FAIL: begin
        cntNext = cnt;
        if (resetCmd) stNext = ST_IDLE;
      end
      ST_RECOVER: begin
        if (cnt == REC_END) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      eraseSet <= '0;
    end else begin
      st       <= stNext;
      cnt      <= cntNext;
      eraseSet <= setNext;
    end
  end

  assign toggling = (st == ST_PROG) || (st == ST_WINDOW) || (st == ST_ERASE) ||
                    (st == ST_PROTWAIT) || (st == ST_FAIL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    tog <= 1'b0;
    else if (rdStrobe && toggling) tog <= ~tog;
  end

  always_comb begin
    rdStatus = toggling || ((st == ST_SUSP) && eraseSet[rdBlk]);
    statusByte = {((st == ST_PROG) || (st == ST_FAIL)) ? ~progBit7 : 1'b0,
                  tog,
                  (st == ST_FAIL),
                  1'b0,
                  (st == ST_ERASE) || (st == ST_PROTWAIT) || (st == ST_SUSP),
                  3'b000};
  end

  assign eraseMask = eraseSet;
  assign busy      = toggling || (st == ST_RECOVER);
  assign suspended = (st == ST_SUSP);

  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WINDOW && blkEraseStart && !suspendReq && !resetCmd) |=> (st == ST_WINDOW && cnt == '0)); // R6
  AST_PROT_PROG_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && progStart && protMask[progBlk]) |=> (st == ST_IDLE)); // R8
  AST_PROG_IGNORES_CMDS: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PROG && !progBad && cnt != PROG_END) |=> (st == ST_PROG)); // R10
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FAIL && !resetCmd) |=> (st == ST_FAIL)); // R4
  AST_TOGGLE_HOLD_SUSP: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SUSP) |=> $stable(tog)); // R3
  AST_SUSP_FROM_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspended) |-> ($past(st) == ST_WINDOW || $past(st) == ST_ERASE)); // R9

endmodule

// File: rtl/flash_pe_datapath.sv
module flash_pe_datapath
  import flash_pe_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_BYTES = 4,
  parameter int ADDR_W      = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  peStrobe_t             strobe,
  input  logic [NUM_BLOCKS-1:0] eraseMask,
  input  logic [ADDR_W-1:0]     progAddr,
  input  logic [7:0]            progData,
  input  logic                  rdStrobe,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic                  rdStatus,
  input  logic [7:0]            statusByte,
  output logic                  progBad,
  output logic                  progBit7,
  output logic [7:0]            rdData
);

  localparam int TOTAL = NUM_BLOCKS * BLOCK_BYTES;

  logic [7:0]        mem [TOTAL];
  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0]        tgtData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtAddr <= '0;
      tgtData <= 8'hFF;
    end else if (strobe.latchProg) begin
      tgtAddr <= progAddr;
      tgtData <= progData;
    end
  end

  for (genvar i = 0; i < TOTAL; i++) begin : gByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mem[i] <= 8'hFF;
      else if (strobe.commitErase && eraseMask[i / BLOCK_BYTES])
        mem[i] <= 8'hFF;
      else if (strobe.commitProg && tgtAddr == ADDR_W'(i))
        mem[i] <= mem[i] & tgtData;
    end
  end

  assign progBad  = ((mem[tgtAddr] & tgtData) != tgtData);
  assign progBit7 = tgtData[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= 8'h00;
    else if (rdStrobe) rdData <= rdStatus ? statusByte : mem[rdAddr];
  end

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitProg |=> ((mem[$past(tgtAddr)] & ~$past(mem[tgtAddr])) == 8'h00)); // R2
  AST_STATUS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdStatus) |=> ((rdData & 8'h17) == 8'h00)); // R12

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_pe_pkg::*;
#(
  parameter int NUM_BLOCKS     = 8,
  parameter int BLOCK_BYTES    = 4,
  parameter int PROG_CYCLES    = 10,
  parameter int FAIL_LIMIT     = 40,
  parameter int ERASE_CYCLES   = 30,
  parameter int WINDOW_CYCLES  = 12,
  parameter int PROT_CYCLES    = 15,
  parameter int RECOVER_CYCLES = 6,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int ADDR_W = BLK_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  progStart,
  input  logic [ADDR_W-1:0]     progAddr,
  input  logic [7:0]            progData,
  input  logic                  blkEraseStart,
  input  logic [BLK_W-1:0]      blkIdx,
  input  logic                  chipEraseStart,
  input  logic                  suspendReq,
  input  logic                  resumeReq,
  input  logic                  resetCmd,
  input  logic [NUM_BLOCKS-1:0] protMask,
  input  logic                  rdStrobe,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [7:0]            rdData,
  output logic                  busy,
  output logic                  suspended
);

  peStrobe_t             strobe;
  logic [NUM_BLOCKS-1:0] eraseMask;
  logic                  rdStatus, progBad, progBit7;
  logic [7:0]            statusByte;

  flash_pe_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W),
    .PROG_CYCLES(PROG_CYCLES), .FAIL_LIMIT(FAIL_LIMIT),
    .ERASE_CYCLES(ERASE_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES),
    .PROT_CYCLES(PROT_CYCLES), .RECOVER_CYCLES(RECOVER_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .progStart(progStart), .progBlk(progAddr[ADDR_W-1 -: BLK_W]),
    .blkEraseStart(blkEraseStart), .blkIdx(blkIdx),
    .chipEraseStart(chipEraseStart), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .resetCmd(resetCmd), .protMask(protMask),
    .rdStrobe(rdStrobe), .rdBlk(rdAddr[ADDR_W-1 -: BLK_W]),
    .progBad(progBad), .progBit7(progBit7),
    .strobe(strobe), .eraseMask(eraseMask),
    .rdStatus(rdStatus), .statusByte(statusByte),
    .busy(busy), .suspended(suspended)
  );

  flash_pe_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES), .ADDR_W(ADDR_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eraseMask(eraseMask),
    .progAddr(progAddr), .progData(progData),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .rdStatus(rdStatus), .statusByte(statusByte),
    .progBad(progBad), .progBit7(progBit7), .rdData(rdData)
  );

endmodule

// File: tb/flash_pe_engine_test.sv
module flash_pe_engine_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progStart = 0, blkEraseStart = 0, chipEraseStart = 0;
  logic       suspendReq = 0, resumeReq = 0, resetCmd = 0, rdStrobe = 0;
  logic [4:0] progAddr = '0, rdAddr = '0;
  logic [7:0] progData = '0;
  logic [2:0] blkIdx = '0;
  logic [7:0] protMask = '0;
  logic [7:0] rdData;
  logic       busy, suspended;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_pe_engine uut (
    .clk(clk), .rstN(rstN), .progStart(progStart), .progAddr(progAddr),
    .progData(progData), .blkEraseStart(blkEraseStart), .blkIdx(blkIdx),
    .chipEraseStart(chipEraseStart), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .resetCmd(resetCmd), .protMask(protMask),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .suspended(suspended)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    rdAddr = a; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    v = rdData;
  endtask

  task automatic prog(input logic [4:0] a, input logic [7:0] d);
    progAddr = a; progData = d; progStart = 1'b1;
    @(negedge clk);
    progStart = 1'b0;
  endtask

  task automatic blkErase(input logic [2:0] b);
    blkIdx = b; blkEraseStart = 1'b1;
    @(negedge clk);
    blkEraseStart = 1'b0;
  endtask

  task automatic pulseReset();
    resetCmd = 1'b1; @(negedge clk); resetCmd = 1'b0;
  endtask

  task automatic pulseSuspend();
    suspendReq = 1'b1; @(negedge clk); suspendReq = 1'b0;
  endtask

  task automatic pulseResume();
    resumeReq = 1'b1; @(negedge clk); resumeReq = 1'b0;
  endtask

  task automatic waitIdle(string req);
    int n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    chk({req, " completes"}, {7'd0, busy}, 8'h00);
  endtask

  // R1: reset state and idle read path
  task automatic testReset();
    logic [7:0] v;
    chk("R1 busy after reset", {7'd0, busy}, 8'h00);
    chk("R1 suspended after reset", {7'd0, suspended}, 8'h00);
    rd(5'd0, v);  chk("R1 byte 0 erased", v, 8'hFF);
    rd(5'd31, v); chk("R1 byte 31 erased", v, 8'hFF);
  endtask

  // R2, R3, R12: normal program
  task automatic testProgram();
    logic [7:0] a, b;
    prog(5'd5, 8'hA5);
    chk("R2 busy during program", {7'd0, busy}, 8'h01);
    rd(5'd5, a); rd(5'd5, b);
    chk("R2 poll bit inverted", {7'd0, a[7]}, 8'h00);
    chk("R3 toggle differs while busy", {7'd0, a[6] ^ b[6]}, 8'h01);
    chk("R12 reserved bits zero", a & 8'h17, 8'h00);
    waitIdle("R2 program");
    rd(5'd5, a); chk("R2 programmed value", a, 8'hA5);
    prog(5'd5, 8'h24);
    waitIdle("R2 second program");
    rd(5'd5, a); chk("R2 AND result", a, 8'h24);
  endtask

  // R4: program needing a 0-to-1 change
  task automatic testFail();
    logic [7:0] v;
    prog(5'd5, 8'hFF);
    repeat (45) @(negedge clk);
    chk("R4 still busy after limit", {7'd0, busy}, 8'h01);
    rd(5'd0, v);
    chk("R4 error bit set", v & 8'hA0, 8'h20);
    pulseReset();
    chk("R4 reset clears busy", {7'd0, busy}, 8'h00);
    rd(5'd5, v); chk("R4 byte unchanged", v, 8'h24);
  endtask

  // R10: commands ignored while programming
  task automatic testProgIgnores();
    logic [7:0] v;
    prog(5'd8, 8'h3C);
    pulseReset(); pulseSuspend(); blkErase(3'd2);
    waitIdle("R10 program");
    repeat (2) @(negedge clk);
    chk("R10 no erase started", {7'd0, busy}, 8'h00);
    rd(5'd8, v); chk("R10 data programmed", v, 8'h3C);
  endtask

  // R5, R6: window, restart, erase
  task automatic testWindow();
    logic [7:0] v;
    prog(5'd0, 8'h11); waitIdle("R5 setup");
    prog(5'd4, 8'h22); waitIdle("R5 setup");
    blkErase(3'd0);
    rd(5'd0, v);
    chk("R5 window status", v & 8'h88, 8'h00);
    repeat (4) @(negedge clk);
    blkErase(3'd1);
    repeat (7) @(negedge clk);
    rd(5'd0, v);
    chk("R6 window restarted", v & 8'h08, 8'h00);
    repeat (6) @(negedge clk);
    rd(5'd4, v);
    chk("R5 erase started status", v & 8'h88, 8'h08);
    waitIdle("R5 erase");
    rd(5'd0, v); chk("R5 block0 erased", v, 8'hFF);
    rd(5'd4, v); chk("R6 added block1 erased", v, 8'hFF);
    rd(5'd8, v); chk("R5 block2 untouched", v, 8'h3C);
  endtask

  // R7, R8: protection
  task automatic testProtect();
    logic [7:0] a, b;
    prog(5'd28, 8'h5A); waitIdle("R8 setup");
    protMask = 8'h80;
    prog(5'd28, 8'h00);
    chk("R8 protected program no busy", {7'd0, busy}, 8'h00);
    @(negedge clk);
    chk("R8 still idle", {7'd0, busy}, 8'h00);
    rd(5'd28, a); chk("R8 data unchanged", a, 8'h5A);
    blkErase(3'd7);
    repeat (14) @(negedge clk);
    rd(5'd28, a); rd(5'd28, b);
    chk("R7 protected erase status", a & 8'h88, 8'h08);
    chk("R7 toggle running", {7'd0, a[6] ^ b[6]}, 8'h01);
    waitIdle("R7 protected erase");
    rd(5'd28, a); chk("R7 data kept", a, 8'h5A);
  endtask

  // R9, R3: suspend and resume
  task automatic testSuspend();
    logic [7:0] a, b;
    prog(5'd16, 8'h77); waitIdle("R9 setup");
    prog(5'd20, 8'h66); waitIdle("R9 setup");
    blkErase(3'd4);
    repeat (15) @(negedge clk);
    pulseSuspend();
    chk("R9 suspended flag", {7'd0, suspended}, 8'h01);
    chk("R9 not busy while suspended", {7'd0, busy}, 8'h00);
    rd(5'd20, a); chk("R9 other block readable", a, 8'h66);
    rd(5'd16, a); rd(5'd16, b);
    chk("R9 erase block gives status", a & 8'h88, 8'h08);
    chk("R3 toggle held in suspend", {7'd0, a[6] ^ b[6]}, 8'h00);
    pulseResume();
    waitIdle("R9 resumed erase");
    rd(5'd16, a); chk("R9 erased after resume", a, 8'hFF);
    rd(5'd20, a); chk("R9 neighbour kept", a, 8'h66);
    blkErase(3'd5);
    repeat (3) @(negedge clk);
    pulseSuspend();
    chk("R9 suspend in window", {7'd0, suspended}, 8'h01);
    pulseResume();
    rd(5'd20, a);
    chk("R9 erase starts on resume", a & 8'h08, 8'h08);
    waitIdle("R9 window-suspend erase");
    rd(5'd20, a); chk("R9 block5 erased", a, 8'hFF);
  endtask

  // R11: reset aborts erase, recovery ignores commands
  task automatic testAbort();
    logic [7:0] v;
    prog(5'd24, 8'h42); waitIdle("R11 setup");
    blkErase(3'd6);
    repeat (16) @(negedge clk);
    pulseReset();
    chk("R11 busy during recovery", {7'd0, busy}, 8'h01);
    prog(5'd25, 8'h00);
    waitIdle("R11 recovery");
    rd(5'd24, v); chk("R11 data kept after abort", v, 8'h42);
    rd(5'd25, v); chk("R11 program in recovery ignored", v, 8'hFF);
  endtask

  // R13: chip erase
  task automatic testChip();
    logic [7:0] v;
    chipEraseStart = 1'b1; @(negedge clk); chipEraseStart = 1'b0;
    rd(5'd8, v);
    chk("R13 chip erase starts at once", v & 8'h88, 8'h08);
    waitIdle("R13 chip erase");
    rd(5'd8, v);  chk("R13 block2 erased", v, 8'hFF);
    rd(5'd24, v); chk("R13 block6 erased", v, 8'hFF);
    rd(5'd28, v); chk("R13 protected block kept", v, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testProgram();
    testFail();
    testProgIgnores();
    testWindow();
    testProtect();
    testSuspend();
    testAbort();
    testChip();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule